// File: doc/BRIEF.md
# SPI Addressed GPIO Expander Core

This block is an SPI target that gives a host access to an 8-bit general-purpose I/O port. Access goes through a small byte-wide register file. Up to eight such cores can hang off one chip select, and each one is told apart by a 3-bit strap value. Every frame opens with a command byte. Its upper nibble is a fixed prefix, bits 3..1 carry the target's hardware address, and bit 0 selects read or write. A register address byte follows, and then one or more data bytes, which the host sends on a write or the core returns on a read.

The SPI lines are sampled in the system clock domain, in mode 0 with the most significant bit first. SCK must therefore run well below the system clock: one SCK half period has to be at least six system clock cycles. The port is modelled as three vectors: an input vector, an output vector and an output-enable vector. A separate vector gives the pull-up enable for each pin. Storage-only registers are provided for interrupt enable, compare value and interrupt control, but the core generates no interrupt.

Top module: `gpx_expander`

## Requirements
- R1: After reset every pin is an input (`gpio_oe` = 0x00), `gpio_out` = 0x00, `gpio_pu` = 0x00 and `spi_miso_oe` = 0. Every register resets to zero except the direction register, which resets to 0xFF.
- R2: Frames run in SPI mode 0 while `spi_cs_n` is low. MOSI is taken on the rising edge of SCK, MISO changes on the falling edge, and bytes travel MSB first. Byte 0 is the command: bits 7..4 = 4'b0100, bits 3..1 = hardware address, bit 0 = 1 for read and 0 for write. Byte 1 is the register address, and the bytes after it are data.
- R3: A command whose bits 7..4 differ from 4'b0100 is never accepted. While configuration bit 3 (address check enable) is set, the core accepts a command only when bits 3..1 equal `hw_addr`. While that bit is clear, it accepts any value in bits 3..1.
- R4: When a command is not accepted, the rest of the frame changes no register and no pin, and `spi_miso_oe` stays 0 for the whole frame.
- R5: The register addresses are: 0x00 direction, 0x01 input polarity, 0x02 interrupt enable, 0x03 compare value, 0x04 interrupt control, 0x05 configuration, 0x06 pull-up enable, 0x07 flags, 0x08 capture, 0x09 port, 0x0A output latch. A write data byte stores into the register the pointer selects, and a read of a storage register returns the value stored there.
- R6: A direction bit of 1 makes that pin an input (`gpio_oe` bit 0), and 0 makes it an output (`gpio_oe` bit 1). `gpio_out` always carries the output latch. `gpio_pu` carries the pull-up enable register.
- R7: A read of 0x09 returns the synchronised `gpio_in` XOR the polarity register. A read of 0x0A returns the latch, not the pin levels.
- R8: A write to 0x09 or to 0x0A loads the output latch.
- R9: While configuration bit 5 is 0, the register pointer advances after each data byte, and it wraps from 0x0A or above back to 0x00. While that bit is 1, the pointer holds, so every data byte of the burst uses the same register.
- R10: Reads of 0x07, 0x08 and 0x0B..0xFF return 0x00, and writes to those addresses are ignored.
- R11: Raising `spi_cs_n` aborts the frame. A partly received byte is discarded, `spi_miso_oe` drops, and the next frame starts again from the command byte.
- R12: During the data bytes of an accepted read, `spi_miso_oe` is 1 and MISO shifts out the selected register, MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_addr | input | 3 | Strap value this core answers to |
| spi_sck | input | 1 | SPI serial clock (asynchronous, oversampled) |
| spi_cs_n | input | 1 | Shared active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | MISO driver enable (tri-state control) |
| gpio_in | input | 8 | Pin levels seen at the pads |
| gpio_out | output | 8 | Pin drive values (output latch) |
| gpio_oe | output | 8 | Per-pin output enable |
| gpio_pu | output | 8 | Per-pin pull-up enable |

## Verification
A corrupted register pointer shows up at the ports on the very next read data byte, because MISO then returns the contents of a neighbouring register. On a write burst it shows up within a few system clocks, when the data lands in the wrong register and `gpio_out`, `gpio_oe` or `gpio_pu` move unexpectedly. A frame phase that sticks, or a command decoder that goes wrong, shows as `spi_miso_oe` rising during a frame meant for another core, or as a write that lands even though the address did not match. The bench therefore checks the enable line and the pins after every frame. A broken bit counter makes every following byte shift by one or more bit places, so the next compared read byte comes back scrambled.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] ADR_DIR  = 8'h00;
  localparam logic [BYTE_W-1:0] ADR_POL  = 8'h01;
  localparam logic [BYTE_W-1:0] ADR_IEN  = 8'h02;
  localparam logic [BYTE_W-1:0] ADR_CMP  = 8'h03;
  localparam logic [BYTE_W-1:0] ADR_ICTL = 8'h04;
  localparam logic [BYTE_W-1:0] ADR_CFG  = 8'h05;
  localparam logic [BYTE_W-1:0] ADR_PUL  = 8'h06;
  localparam logic [BYTE_W-1:0] ADR_FLG  = 8'h07;
  localparam logic [BYTE_W-1:0] ADR_CAP  = 8'h08;
  localparam logic [BYTE_W-1:0] ADR_PORT = 8'h09;
  localparam logic [BYTE_W-1:0] ADR_LAT  = 8'h0A;
  localparam logic [BYTE_W-1:0] ADR_LAST = ADR_LAT;

  localparam int CFG_SEQ_OFF = 5;
  localparam int CFG_ADR_EN  = 3;

  localparam logic [3:0] CMD_PREFIX = 4'b0100;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/gpx_spi_shifter.sv
module gpx_spi_shifter
  import gpx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              cs_active,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  logic [SYNC_STAGES-1:0] sck_pipe, cs_pipe, mosi_pipe;
  logic                   sck_prev;
  logic                   sck_s, mosi_s;
  logic                   sck_rise, sck_fall;
  logic [CNT_W-1:0]       bit_cnt;
  logic [BYTE_W-1:0]      rx_sh;
  logic [BYTE_W-1:0]      tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_pipe  <= '0;
      cs_pipe   <= '1;
      mosi_pipe <= '0;
      sck_prev  <= 1'b0;
    end else begin
      sck_pipe  <= {sck_pipe[SYNC_STAGES-2:0], spi_sck};
      cs_pipe   <= {cs_pipe[SYNC_STAGES-2:0], spi_cs_n};
      mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], spi_mosi};
      sck_prev  <= sck_s;
    end
  end

  assign sck_s     = sck_pipe[SYNC_STAGES-1];
  assign mosi_s    = mosi_pipe[SYNC_STAGES-1];
  assign cs_active = ~cs_pipe[SYNC_STAGES-1];
  assign sck_rise  = sck_s & ~sck_prev;
  assign sck_fall  = ~sck_s & sck_prev;

  // receive side: bits taken on rising SCK
  always_ff @(posedge clk) begin
    if (rst || !cs_active) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      byte_valid <= 1'b0;
      rx_byte    <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (sck_rise) begin
        rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          byte_valid <= 1'b1;
          rx_byte    <= {rx_sh[BYTE_W-2:0], mosi_s};
        end
      end
    end
  end

  // transmit side: a loaded byte is held across the boundary fall, then shifts
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
    end else if (tx_load) begin
      tx_sh <= tx_byte;
    end else if (cs_active && sck_fall && bit_cnt != '0) begin
      tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
    end
  end

  assign miso = tx_sh[BYTE_W-1];

  assert_byte_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);
endmodule

// File: rtl/gpx_frame_ctrl.sv
module gpx_frame_ctrl
  import gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_active,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [2:0]        hw_addr,
  input  logic [BYTE_W-1:0] cfg_q,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              miso_oe
);
  phase_t            phase;
  logic              is_read;
  logic [BYTE_W-1:0] ptr;
  logic [BYTE_W-1:0] ptr_next;
  logic              cmd_match;
  logic              seq_on;

  assign seq_on    = ~cfg_q[CFG_SEQ_OFF];
  assign cmd_match = (rx_byte[7:4] == CMD_PREFIX) &&
                     (!cfg_q[CFG_ADR_EN] || rx_byte[3:1] == hw_addr);

  always_comb begin
    ptr_next = ptr;
    if (seq_on) ptr_next = (ptr >= ADR_LAST) ? '0 : ptr + 1'b1;
  end

  assign rd_addr = (phase == PH_ADDR) ? rx_byte : ptr_next;
  assign tx_byte = rd_data;
  assign tx_load = byte_valid && is_read && (phase == PH_ADDR || phase == PH_DATA);
  assign wr_en   = byte_valid && !is_read && (phase == PH_DATA);
  assign wr_addr = ptr;
  assign wr_data = rx_byte;

  always_ff @(posedge clk) begin
    if (rst || !cs_active) begin
      phase   <= PH_CMD;
      is_read <= 1'b0;
      ptr     <= '0;
      miso_oe <= 1'b0;
    end else if (byte_valid) begin
      case (phase)
        PH_CMD: begin
          if (cmd_match) begin
            phase   <= PH_ADDR;
            is_read <= rx_byte[0];
          end else begin
            phase <= PH_SKIP;
          end
        end
        PH_ADDR: begin
          ptr     <= rx_byte;
          phase   <= PH_DATA;
          miso_oe <= is_read;
        end
        PH_DATA: ptr <= ptr_next;
        default: phase <= PH_SKIP;
      endcase
    end
  end

  assert_bad_prefix_skips_R3: assert property (@(posedge clk) disable iff (rst)
    (cs_active && byte_valid && phase == PH_CMD && rx_byte[7:4] != CMD_PREFIX)
      |=> (phase == PH_SKIP));

  assert_skip_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |-> (!miso_oe && !wr_en));

  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cs_active && byte_valid && phase == PH_DATA && cfg_q[CFG_SEQ_OFF])
      |=> $stable(ptr));

  assert_release_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !cs_active |=> !miso_oe);
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] gpio_in,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] gpio_out,
  output logic [BYTE_W-1:0] gpio_oe,
  output logic [BYTE_W-1:0] gpio_pu
);
  logic [BYTE_W-1:0] in_pipe [SYNC_STAGES];
  logic [BYTE_W-1:0] dir_q, pol_q, ien_q, cmp_q, ictl_q, pul_q, lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) in_pipe[s] <= '0;
    end else begin
      in_pipe[0] <= gpio_in;
      for (int s = 1; s < SYNC_STAGES; s++) in_pipe[s] <= in_pipe[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      pol_q  <= '0;
      ien_q  <= '0;
      cmp_q  <= '0;
      ictl_q <= '0;
      cfg_q  <= '0;
      pul_q  <= '0;
      lat_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_DIR:           dir_q  <= wr_data;
        ADR_POL:           pol_q  <= wr_data;
        ADR_IEN:           ien_q  <= wr_data;
        ADR_CMP:           cmp_q  <= wr_data;
        ADR_ICTL:          ictl_q <= wr_data;
        ADR_CFG:           cfg_q  <= wr_data;
        ADR_PUL:           pul_q  <= wr_data;
        ADR_PORT, ADR_LAT: lat_q  <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      ADR_DIR:  rd_data = dir_q;
      ADR_POL:  rd_data = pol_q;
      ADR_IEN:  rd_data = ien_q;
      ADR_CMP:  rd_data = cmp_q;
      ADR_ICTL: rd_data = ictl_q;
      ADR_CFG:  rd_data = cfg_q;
      ADR_PUL:  rd_data = pul_q;
      ADR_PORT: rd_data = in_pipe[SYNC_STAGES-1] ^ pol_q;
      ADR_LAT:  rd_data = lat_q;
      default:  rd_data = '0;
    endcase
  end

  assign gpio_out = lat_q;
  assign gpio_oe  = ~dir_q;
  assign gpio_pu  = pul_q;

  assert_no_stray_write_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(lat_q) && $stable(dir_q) && $stable(pul_q)));

  assert_port_to_latch_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADR_PORT) |=> (gpio_out == $past(wr_data)));
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
  import gpx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        hw_addr,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [BYTE_W-1:0] gpio_in,
  output logic [BYTE_W-1:0] gpio_out,
  output logic [BYTE_W-1:0] gpio_oe,
  output logic [BYTE_W-1:0] gpio_pu
);
  logic              cs_active, byte_valid, tx_load, wr_en;
  logic [BYTE_W-1:0] rx_byte, tx_byte, rd_addr, rd_data;
  logic [BYTE_W-1:0] wr_addr, wr_data, cfg_q;

  gpx_spi_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .tx_load(tx_load), .tx_byte(tx_byte),
    .cs_active(cs_active), .byte_valid(byte_valid), .rx_byte(rx_byte),
    .miso(spi_miso)
  );

  gpx_frame_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cs_active(cs_active), .byte_valid(byte_valid),
    .rx_byte(rx_byte), .hw_addr(hw_addr), .cfg_q(cfg_q), .rd_data(rd_data),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_load(tx_load), .tx_byte(tx_byte), .miso_oe(spi_miso_oe)
  );

  gpx_regfile #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rst(rst), .gpio_in(gpio_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .cfg_q(cfg_q), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .gpio_pu(gpio_pu)
  );
endmodule

// File: tb/test_gpx_expander.sv
module test_gpx_expander;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hw_addr = 3'b101;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic [7:0] gpio_in = 8'h00;
  logic       miso, miso_oe;
  logic [7:0] gpio_out, gpio_oe, gpio_pu;

  int checks = 0;
  int errors = 0;
  logic seen_oe = 1'b0;

  logic [7:0] exp_q[$];
  string      req_q[$];

  always #5 clk = ~clk;

  gpx_expander i_gpx_expander (
    .clk(clk), .rst(rst), .hw_addr(hw_addr), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_pu(gpio_pu)
  );

  // monitor: assemble read bytes while MISO is enabled, compare to scoreboard
  logic [7:0] mbuf = 8'h00;
  int         mcnt = 0;
  always @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      mcnt = 0;
    end else if (miso_oe) begin
      mbuf = {mbuf[6:0], miso};
      mcnt++;
      if (mcnt == 8) begin
        mcnt = 0;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R4 unexpected read byte: actual %h expected none", mbuf);
        end else begin
          logic [7:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          if (mbuf !== e) begin
            errors++;
            $display("FAIL %s read byte: actual %h expected %h", r, mbuf, e);
          end
        end
      end
    end
  end

  function automatic logic [7:0] cmd(input logic [2:0] a, input logic rd);
    return {4'b0100, a, rd};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b);
    mosi = b;
    #80;
    if (miso_oe) seen_oe = 1'b1;
    sck = 1'b1;
    #80;
    sck = 1'b0;
    if (miso_oe) seen_oe = 1'b1;
  endtask

  task automatic spi_byte(input logic [7:0] tx);
    for (int i = 7; i >= 0; i--) spi_bit(tx[i]);
  endtask

  task automatic cs_low;
    @(negedge clk);
    cs_n = 1'b0;
    #80;
  endtask

  task automatic cs_high;
    #80;
    cs_n = 1'b1;
    #200;
  endtask

  task automatic wr1(input logic [2:0] a, input logic [7:0] adr, input logic [7:0] d);
    cs_low;
    spi_byte(cmd(a, 1'b0));
    spi_byte(adr);
    spi_byte(d);
    cs_high;
  endtask

  task automatic expect_rd(input logic [7:0] e, input string r);
    exp_q.push_back(e);
    req_q.push_back(r);
  endtask

  task automatic rd_start(input logic [2:0] a, input logic [7:0] adr);
    cs_low;
    spi_byte(cmd(a, 1'b1));
    spi_byte(adr);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 oe", gpio_oe, 8'h00);
    chk("R1 out", gpio_out, 8'h00);
    chk("R1 pu", gpio_pu, 8'h00);
    chk("R1 miso_oe", {7'd0, miso_oe}, 8'h00);

    // R3 with address check off any address field is accepted; R5 R6 direction
    wr1(3'b000, 8'h00, 8'h0F);
    chk("R6 direction", gpio_oe, 8'hF0);

    // R8 port write lands in latch
    wr1(3'b011, 8'h09, 8'hA5);
    chk("R8 port write", gpio_out, 8'hA5);

    // R7 latch readback, R12 enable during read
    seen_oe = 1'b0;
    expect_rd(8'hA5, "R7 latch read");
    rd_start(3'b000, 8'h0A); spi_byte(8'h00); cs_high;
    chk("R12 miso_oe seen", {7'd0, seen_oe}, 8'h01);

    // R7 polarity applied to port read
    gpio_in = 8'h3C;
    wr1(3'b000, 8'h01, 8'h0F);
    expect_rd(8'h33, "R7 port polarity");
    rd_start(3'b000, 8'h09); spi_byte(8'h00); cs_high;

    // R9 burst write walking 0x06..0x09, R10 flags/capture ignored
    cs_low;
    spi_byte(cmd(3'b000, 1'b0)); spi_byte(8'h06);
    spi_byte(8'h81); spi_byte(8'hEE); spi_byte(8'hEE); spi_byte(8'h5A);
    cs_high;
    chk("R9 burst pull-up", gpio_pu, 8'h81);
    chk("R9 burst port", gpio_out, 8'h5A);

    // R9 burst read with wrap from 0x0A to 0x00
    expect_rd(8'h33, "R9 burst port");
    expect_rd(8'h5A, "R9 burst latch");
    expect_rd(8'h0F, "R9 wrap dir");
    expect_rd(8'h0F, "R9 wrap pol");
    rd_start(3'b000, 8'h09);
    for (int k = 0; k < 4; k++) spi_byte(8'h00);
    cs_high;

    // R10 flags, capture and unmapped read zero
    expect_rd(8'h00, "R10 flags");
    expect_rd(8'h00, "R10 capture");
    rd_start(3'b000, 8'h07); spi_byte(8'h00); spi_byte(8'h00); cs_high;
    expect_rd(8'h00, "R10 unmapped");
    expect_rd(8'h0F, "R10 wrap after unmapped");
    rd_start(3'b000, 8'h0B); spi_byte(8'h00); spi_byte(8'h00); cs_high;

    // enable address check and disable sequential mode
    wr1(3'b000, 8'h05, 8'h28);

    // R3 R4 mismatched address: write ignored, no MISO drive on read
    wr1(3'b010, 8'h0A, 8'hFF);
    chk("R4 mismatch write", gpio_out, 8'h5A);
    seen_oe = 1'b0;
    rd_start(3'b010, 8'h0A); spi_byte(8'h00); cs_high;
    chk("R4 mismatch miso_oe", {7'd0, seen_oe}, 8'h00);

    // R9 sequential off: burst hits one register
    cs_low;
    spi_byte(cmd(3'b101, 1'b0)); spi_byte(8'h0A);
    spi_byte(8'h11); spi_byte(8'h22);
    cs_high;
    chk("R9 hold latch", gpio_out, 8'h22);
    chk("R9 hold pull-up", gpio_pu, 8'h81);
    expect_rd(8'h22, "R9 hold read 0");
    expect_rd(8'h22, "R9 hold read 1");
    rd_start(3'b101, 8'h0A); spi_byte(8'h00); spi_byte(8'h00); cs_high;

    // R3 wrong prefix never accepted
    cs_low;
    spi_byte(8'h5A); spi_byte(8'h0A); spi_byte(8'h77);
    cs_high;
    chk("R3 bad prefix", gpio_out, 8'h22);

    // R11 abort mid byte, then recover
    cs_low;
    spi_byte(cmd(3'b101, 1'b0)); spi_byte(8'h0A);
    for (int k = 0; k < 4; k++) spi_bit(1'b1);
    cs_high;
    chk("R11 abort", gpio_out, 8'h22);
    wr1(3'b101, 8'h0A, 8'h44);
    chk("R11 recover", gpio_out, 8'h44);

    // R5 config readback with sequential back on
    wr1(3'b101, 8'h05, 8'h08);
    expect_rd(8'h08, "R5 config read");
    expect_rd(8'h81, "R5 pull-up read");
    rd_start(3'b101, 8'h05); spi_byte(8'h00); spi_byte(8'h00); cs_high;
    chk("R11 miso_oe after frame", {7'd0, miso_oe}, 8'h00);

    repeat (10) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R12 missing read bytes: actual %0d left expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule